// File: doc/BRIEF.md
# UART Command Bridge for a Burst Memory Master

This block turns a byte stream arriving from a UART receiver into memory operations for a burst-capable memory master. The host sends a short command frame. The frame holds an opcode, a 32-bit address and, for writes, a 64-bit data word. Once the last byte of the frame is in, the bridge starts the master with the operation type, the address and the first data word. For burst writes the master's own data generator supplies the following incremented words. The host therefore sends only the start address and the first word.

A write ends with one status byte returned to the host. On a read, the bridge stores every 64-bit beat the master returns in a buffer that is written one word at a time and read one byte at a time. Nothing goes back to the host until the master reports that the whole read has finished. The stored bytes are then streamed out through the byte transmitter. A single read returns 8 bytes and a burst read returns 2048 bytes.

The UART bit-level serialiser and the memory are outside this block. It sees only byte-wide valid/ready style strobes on the host side and a start/done handshake on the master side.

Top module: `uart_cmd_bridge`

## Requirements
- R1: A frame is one opcode byte, then 4 address bytes with the most significant byte first, then, for write opcodes only, 8 data bytes with the most significant byte first. While `mstStart` is high, `mstAddr` and `mstData` carry the assembled values.
- R2: Opcode 0x01 is a single write, 0x02 a single read, 0x03 a burst write and 0x04 a burst read. While `mstStart` is high, `mstWrite` is 1 for 0x01 and 0x03, and `mstBurst` is 1 for 0x03 and 0x04.
- R3: A byte received while idle that is not one of the four opcodes is discarded. It produces no `mstStart` and no transmitted byte, and the next valid frame is parsed normally.
- R4: `mstStart` is a pulse exactly one cycle long. It rises in the cycle after the clock edge that accepts the last byte of a frame, once per frame.
- R5: A write ends with exactly one transmitted byte. The byte is 0xAA if `mstErr` was low with `mstDone`, or 0xEE if it was high.
- R6: Read beats are stored in arrival order while the master operation is open. No byte is offered to the transmitter before `mstDone` arrives.
- R7: After `mstDone`, a single read sends exactly 8 bytes and a burst read sends exactly 2048 bytes. Beats go out in arrival order, and each 64-bit beat goes out least significant byte first, so byte n is bits [8*(n%8)+7 : 8*(n%8)] of beat n/8.
- R8: A byte is handed over only on a cycle where both `txValid` and `txReady` are high. While `txReady` is low, `txValid` stays high and `txByte` holds its value.
- R9: After the last byte of an operation has been handed over, the bridge stays busy until `txReady` is high again. Bytes received during that wait are discarded.
- R10: If IDLE_LIMIT consecutive cycles pass without a received byte in the middle of a frame (default 65536), the partial frame is dropped and the next byte is read as an opcode. A gap shorter than that lets the frame complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe: a received byte is on rxByte |
| rxByte | input | 8 | Received byte |
| txReady | input | 1 | Transmitter can take a byte / is idle |
| txValid | output | 1 | A byte is offered on txByte |
| txByte | output | 8 | Byte offered to the transmitter |
| mstStart | output | 1 | One-cycle start pulse to the memory master |
| mstWrite | output | 1 | Operation is a write |
| mstBurst | output | 1 | Operation is a burst rather than a single beat |
| mstAddr | output | 32 | Start address of the operation |
| mstData | output | 64 | First (or only) write data word |
| mstDone | input | 1 | One-cycle strobe: the master finished the operation |
| mstErr | input | 1 | Error status, valid with mstDone |
| rdBeatValid | input | 1 | One-cycle strobe: a read beat is on rdBeatData |
| rdBeatData | input | 64 | Read beat from the master |

## Verification
A parser that loses its place in a frame shows up at the start pulse. The pulse comes one byte early or late, or the address arrives with its bytes shifted, on the same cycle the frame closes. A wrong buffer or stream pointer shows up in the returned byte stream. The bench compares every byte against the beats it supplied, so a swapped lane, a skipped beat or a wrong count is seen at the first bad byte or at the end-of-stream count. A bridge stuck in a wait state shows up within a few cycles as a missing start pulse or as a byte accepted while it should be busy.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam logic [7:0] OPC_WRITE_ONE  = 8'h01;
  localparam logic [7:0] OPC_READ_ONE   = 8'h02;
  localparam logic [7:0] OPC_WRITE_BURST = 8'h03;
  localparam logic [7:0] OPC_READ_BURST = 8'h04;

  localparam logic [7:0] ACK_OK  = 8'hAA;
  localparam logic [7:0] ACK_ERR = 8'hEE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_LAUNCH,
    ST_WAIT,
    ST_ACK,
    ST_STREAM,
    ST_DRAIN
  } bridgeState_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic shiftAddr;
    logic shiftData;
    logic rewind;
    logic capEn;
    logic rdStep;
    logic sendAck;
    logic ackErr;
    logic burst;
  } dpCtl_t;

  typedef struct packed {
    logic known;
    logic write;
    logic burst;
  } opInfo_t;

  function automatic opInfo_t decodeOp(input logic [7:0] code);
    opInfo_t info;
    info = '0;
    case (code)
      OPC_WRITE_ONE:   info = '{known: 1'b1, write: 1'b1, burst: 1'b0};
      OPC_READ_ONE:    info = '{known: 1'b1, write: 1'b0, burst: 1'b0};
      OPC_WRITE_BURST: info = '{known: 1'b1, write: 1'b1, burst: 1'b1};
      OPC_READ_BURST:  info = '{known: 1'b1, write: 1'b0, burst: 1'b1};
      default:         info = '0;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/wide_narrow_buf.sv
module wide_narrow_buf #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 64
) (
  input  logic                                         clk,
  input  logic                                         wrEn,
  input  logic [$clog2(DEPTH)-1:0]                     wrPtr,
  input  logic [WORD_W-1:0]                            wrWord,
  input  logic [$clog2(DEPTH*(WORD_W/8))-1:0]          rdIdx,
  output logic [7:0]                                   rdByte
);
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = $clog2(DEPTH * LANES);

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] rdWord;
  logic [7:0]        laneBytes [LANES];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrPtr] <= wrWord;
  end

  assign rdWord = store[rdIdx[IDX_W-1:LANE_W]];

  // byte lane 0 is the least significant byte of the stored word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneBytes[g] = rdWord[8*g +: 8];
  end

  assign rdByte = laneBytes[rdIdx[LANE_W-1:0]];

endmodule

// File: rtl/uart_cmd_dpath.sv
module uart_cmd_dpath
  import uart_cmd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BUF_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxByte,
  input  dpCtl_t            dpCtl,
  input  logic              rdBeatValid,
  input  logic [DATA_W-1:0] rdBeatData,
  output logic [ADDR_W-1:0] mstAddr,
  output logic [DATA_W-1:0] mstData,
  output logic [7:0]        txByte,
  output logic              rdLast
);
  localparam int WORD_BYTES  = DATA_W / 8;
  localparam int BURST_BYTES = BUF_DEPTH * WORD_BYTES;
  localparam int IDX_W       = $clog2(BURST_BYTES);
  localparam int PTR_W       = $clog2(BUF_DEPTH);
  localparam logic [IDX_W-1:0] LAST_BURST  = IDX_W'(BURST_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_SINGLE = IDX_W'(WORD_BYTES - 1);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [PTR_W-1:0]  wrPtr;
  logic [IDX_W-1:0]  rdIdx;
  logic [7:0]        bufByte;
  logic              beatWr;

  // frame bytes arrive most significant first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (dpCtl.shiftAddr) addrQ <= {addrQ[ADDR_W-9:0], rxByte};
      if (dpCtl.shiftData) dataQ <= {dataQ[DATA_W-9:0], rxByte};
    end
  end

  assign beatWr = dpCtl.capEn && rdBeatValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdIdx <= '0;
    end else begin
      if (dpCtl.rewind)   wrPtr <= '0;
      else if (beatWr)    wrPtr <= wrPtr + 1'b1;
      if (dpCtl.rewind)   rdIdx <= '0;
      else if (dpCtl.rdStep) rdIdx <= rdIdx + 1'b1;
    end
  end

  wide_narrow_buf #(
    .DEPTH (BUF_DEPTH),
    .WORD_W(DATA_W)
  ) u_buf (
    .clk   (clk),
    .wrEn  (beatWr),
    .wrPtr (wrPtr),
    .wrWord(rdBeatData),
    .rdIdx (rdIdx),
    .rdByte(bufByte)
  );

  assign rdLast  = (rdIdx == (dpCtl.burst ? LAST_BURST : LAST_SINGLE));
  assign txByte  = dpCtl.sendAck ? (dpCtl.ackErr ? ACK_ERR : ACK_OK) : bufByte;
  assign mstAddr = addrQ;
  assign mstData = dataQ;

endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int DATA_BYTES = 8,
  parameter int IDLE_LIMIT = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReady,
  input  logic       mstDone,
  input  logic       mstErr,
  input  logic       rdLast,
  output logic       txValid,
  output logic       mstStart,
  output logic       mstWrite,
  output logic       mstBurst,
  output dpCtl_t     dpCtl
);
  localparam int MAX_BYTES = (DATA_BYTES > ADDR_BYTES) ? DATA_BYTES : ADDR_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES);
  localparam int TMR_W     = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BYTES - 1);
  localparam logic [TMR_W-1:0] TMR_END   = TMR_W'(IDLE_LIMIT - 1);

  bridgeState_t state, stateN;
  logic [CNT_W-1:0] byteCnt;
  logic [TMR_W-1:0] gapTmr;
  logic             opWrite, opBurst, errQ;
  opInfo_t          rxOp;
  logic             inFrame;

  assign rxOp    = decodeOp(rxByte);
  assign inFrame = (state == ST_ADDR) || (state == ST_DATA);

  always_comb begin
    stateN        = state;
    dpCtl         = '0;
    dpCtl.burst   = opBurst;
    dpCtl.ackErr  = errQ;
    txValid       = 1'b0;
    mstStart      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (rxValid && rxOp.known) stateN = ST_ADDR;
      end
      ST_ADDR: begin
        if (rxValid) begin
          dpCtl.shiftAddr = 1'b1;
          if (byteCnt == LAST_ADDR) stateN = opWrite ? ST_DATA : ST_LAUNCH;
        end else if (gapTmr == TMR_END) begin
          stateN = ST_IDLE;
        end
      end
      ST_DATA: begin
        if (rxValid) begin
          dpCtl.shiftData = 1'b1;
          if (byteCnt == LAST_DATA) stateN = ST_LAUNCH;
        end else if (gapTmr == TMR_END) begin
          stateN = ST_IDLE;
        end
      end
      ST_LAUNCH: begin
        mstStart     = 1'b1;
        dpCtl.rewind = 1'b1;
        stateN       = ST_WAIT;
      end
      ST_WAIT: begin
        dpCtl.capEn = 1'b1;
        if (mstDone) stateN = opWrite ? ST_ACK : ST_STREAM;
      end
      ST_ACK: begin
        txValid       = 1'b1;
        dpCtl.sendAck = 1'b1;
        if (txReady) stateN = ST_DRAIN;
      end
      ST_STREAM: begin
        txValid = 1'b1;
        if (txReady) begin
          dpCtl.rdStep = 1'b1;
          if (rdLast) stateN = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (txReady) stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
      gapTmr  <= '0;
      opWrite <= 1'b0;
      opBurst <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      state <= stateN;
      if (state == ST_IDLE) begin
        byteCnt <= '0;
        if (rxValid && rxOp.known) begin
          opWrite <= rxOp.write;
          opBurst <= rxOp.burst;
        end
      end else if (dpCtl.shiftAddr || dpCtl.shiftData) begin
        byteCnt <= (stateN != state) ? '0 : byteCnt + 1'b1;
      end
      if (inFrame && !rxValid) gapTmr <= gapTmr + 1'b1;
      else                     gapTmr <= '0;
      if (state == ST_WAIT && mstDone) errQ <= mstErr;
    end
  end

  assign mstWrite = opWrite;
  assign mstBurst = opBurst;

endmodule

// File: rtl/uart_cmd_bridge.sv
module uart_cmd_bridge
  import uart_cmd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int BUF_DEPTH  = 256,
  parameter int IDLE_LIMIT = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              txReady,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              mstStart,
  output logic              mstWrite,
  output logic              mstBurst,
  output logic [ADDR_W-1:0] mstAddr,
  output logic [DATA_W-1:0] mstData,
  input  logic              mstDone,
  input  logic              mstErr,
  input  logic              rdBeatValid,
  input  logic [DATA_W-1:0] rdBeatData
);
  dpCtl_t dpCtl;
  logic   rdLast;

  uart_cmd_ctrl #(
    .ADDR_BYTES(ADDR_W / 8),
    .DATA_BYTES(DATA_W / 8),
    .IDLE_LIMIT(IDLE_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .rxByte  (rxByte),
    .txReady (txReady),
    .mstDone (mstDone),
    .mstErr  (mstErr),
    .rdLast  (rdLast),
    .txValid (txValid),
    .mstStart(mstStart),
    .mstWrite(mstWrite),
    .mstBurst(mstBurst),
    .dpCtl   (dpCtl)
  );

  uart_cmd_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BUF_DEPTH(BUF_DEPTH)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .rxByte     (rxByte),
    .dpCtl      (dpCtl),
    .rdBeatValid(rdBeatValid),
    .rdBeatData (rdBeatData),
    .mstAddr    (mstAddr),
    .mstData    (mstData),
    .txByte     (txByte),
    .rdLast     (rdLast)
  );

endmodule

// File: rtl/uart_cmd_checker.sv
module uart_cmd_checker
  import uart_cmd_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int BUF_DEPTH = 256
) (
  input logic       clk,
  input logic       rstN,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] txByte,
  input logic       mstStart,
  input logic       mstWrite
);
  localparam int MAX_BYTES = BUF_DEPTH * (DATA_W / 8);

  int sentCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                  sentCnt <= 0;
    else if (mstStart)          sentCnt <= 0;
    else if (txValid && txReady) sentCnt <= sentCnt + 1;
  end

  // R4: start is a single-cycle pulse
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    mstStart |=> !mstStart);

  // R6: nothing offered to the transmitter while an operation is launched
  p_quiet_at_launch_r6: assert property (@(posedge clk) disable iff (!rstN)
    mstStart |-> !txValid);

  // R5: a write only ever returns one of the two status codes
  p_ack_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && mstWrite) |-> (txByte == ACK_OK || txByte == ACK_ERR));

  // R8: an offered byte is held until taken
  p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte)));

  // R7: never more bytes per operation than a full burst
  p_byte_budget_r7: assert property (@(posedge clk) disable iff (!rstN)
    sentCnt <= MAX_BYTES);

endmodule

bind uart_cmd_bridge uart_cmd_checker #(
  .DATA_W   (DATA_W),
  .BUF_DEPTH(BUF_DEPTH)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .txValid (txValid),
  .txReady (txReady),
  .txByte  (txByte),
  .mstStart(mstStart),
  .mstWrite(mstWrite)
);

// File: tb/tb_uart_cmd_bridge.sv
`timescale 1ns/1ps
module tb_uart_cmd_bridge;
  localparam int CYC   = 10;
  localparam int LIMIT = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        txReady = 1'b0;
  logic        txValid;
  logic [7:0]  txByte;
  logic        mstStart, mstWrite, mstBurst;
  logic [31:0] mstAddr;
  logic [63:0] mstData;
  logic        mstDone = 1'b0;
  logic        mstErr = 1'b0;
  logic        rdBeatValid = 1'b0;
  logic [63:0] rdBeatData = '0;

  int total = 0;
  int bad = 0;
  int txMode = 0;
  int gotCount = 0;
  int startCount = 0;
  logic [7:0]  got [2048];
  logic [63:0] beatMem [256];

  always #(CYC/2) clk = ~clk;

  uart_cmd_bridge #(.IDLE_LIMIT(LIMIT)) dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .txReady(txReady), .txValid(txValid), .txByte(txByte),
    .mstStart(mstStart), .mstWrite(mstWrite), .mstBurst(mstBurst),
    .mstAddr(mstAddr), .mstData(mstData), .mstDone(mstDone), .mstErr(mstErr),
    .rdBeatValid(rdBeatValid), .rdBeatData(rdBeatData)
  );

  // transmitter model and monitor, all at the falling edge
  always @(negedge clk) begin
    case (txMode)
      0: txReady = ($urandom % 4) != 0;
      1: txReady = 1'b0;
      3: begin txReady = 1'b1; txMode = 1; end
      default: txReady = 1'b1;
    endcase
    if (rstN && txValid && txReady) begin
      if (gotCount < 2048) got[gotCount] = txByte;
      gotCount++;
    end
    if (rstN && mstStart) startCount++;
  end

  function automatic bit isWrite(input logic [7:0] opc);
    return opc == 8'h01 || opc == 8'h03;
  endfunction
  function automatic bit isBurst(input logic [7:0] opc);
    return opc == 8'h03 || opc == 8'h04;
  endfunction
  function automatic int expBytes(input logic [7:0] opc);
    if (isWrite(opc)) return 1;
    return isBurst(opc) ? 2048 : 8;
  endfunction
  function automatic logic [7:0] expReadByte(input int n);
    logic [63:0] w;
    w = beatMem[n / 8];
    return w[8*(n % 8) +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] opc, input logic [31:0] addr,
                           input logic [63:0] data);
    sendByte(opc, $urandom % 3);
    for (int i = 3; i >= 0; i--) sendByte(addr[8*i +: 8], $urandom % 3);
    if (isWrite(opc))
      for (int i = 7; i >= 0; i--) sendByte(data[8*i +: 8], $urandom % 3);
  endtask

  // frame already sent; we stand in the launch cycle
  task automatic checkLaunch(input logic [7:0] opc, input logic [31:0] addr,
                             input logic [63:0] data, input int sc0);
    chk(mstStart == 1'b1, "R4", "start right after last byte", {63'd0, mstStart}, 64'd1);
    chk(mstAddr == addr, "R1", "address assembled", {32'd0, mstAddr}, {32'd0, addr});
    if (isWrite(opc))
      chk(mstData == data, "R1", "data assembled", mstData, data);
    chk(mstWrite == isWrite(opc) && mstBurst == isBurst(opc), "R2", "op flags",
        {62'd0, mstWrite, mstBurst}, {62'd0, isWrite(opc), isBurst(opc)});
    @(negedge clk);
    chk(mstStart == 1'b0 && startCount == sc0 + 1, "R4", "single start pulse",
        startCount - sc0, 1);
  endtask

  task automatic serveOp(input logic [7:0] opc, input bit err);
    int n;
    n = isWrite(opc) ? 0 : (isBurst(opc) ? 256 : 1);
    for (int i = 0; i < n; ) begin
      @(negedge clk);
      if ($urandom % 4 == 0) rdBeatValid = 1'b0;
      else begin
        rdBeatValid = 1'b1;
        rdBeatData = {$urandom, $urandom};
        beatMem[i] = rdBeatData;
        i++;
      end
    end
    @(negedge clk); rdBeatValid = 1'b0;
    repeat ($urandom % 5) @(negedge clk);
    chk(gotCount == 0 && txValid == 1'b0, "R6", "no byte before done", gotCount, 0);
    mstDone = 1'b1; mstErr = err;
    @(negedge clk); mstDone = 1'b0; mstErr = 1'b0;
  endtask

  task automatic collect(input logic [7:0] opc, input bit err);
    int want, w, badIdx;
    want = expBytes(opc);
    w = 0;
    while (gotCount < want && w < 20000) begin @(negedge clk); w++; end
    repeat (12) @(negedge clk);
    chk(gotCount == want, isWrite(opc) ? "R5" : "R7", "byte count", gotCount, want);
    if (isWrite(opc)) begin
      chk(got[0] == (err ? 8'hEE : 8'hAA), "R5", "status byte", {56'd0, got[0]},
          {56'd0, (err ? 8'hEE : 8'hAA)});
    end else begin
      badIdx = -1;
      for (int i = 0; i < want; i++)
        if (badIdx < 0 && got[i] != expReadByte(i)) badIdx = i;
      if (badIdx < 0) chk(1'b1, "R7", "read byte order", 0, 0);
      else chk(1'b0, "R7", $sformatf("read byte %0d", badIdx), {56'd0, got[badIdx]},
               {56'd0, expReadByte(badIdx)});
    end
  endtask

  task automatic runCmd(input logic [7:0] opc, input logic [31:0] addr,
                        input logic [63:0] data, input bit err);
    int sc0;
    gotCount = 0;
    sc0 = startCount;
    sendFrame(opc, addr, data);
    checkLaunch(opc, addr, data, sc0);
    serveOp(opc, err);
    collect(opc, err);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL R4 watchdog: act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sc0;
    logic [7:0] opc;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    chk(txValid == 1'b0 && mstStart == 1'b0, "R8", "reset outputs quiet",
        {62'd0, txValid, mstStart}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // directed: each operation type
    runCmd(8'h01, 32'h0000_1238, 64'h0123_4567_89AB_CDEF, 1'b0);
    runCmd(8'h01, 32'h03FF_FFF8, 64'hFEDC_BA98_7654_3210, 1'b1);
    runCmd(8'h02, 32'h0000_1238, 64'd0, 1'b0);
    runCmd(8'h03, 32'h0000_4000, 64'h0000_0000_0000_00FF, 1'b0);
    runCmd(8'h04, 32'h03FF_F7F8, 64'd0, 1'b1);

    // R3: unknown opcodes ignored
    gotCount = 0;
    sc0 = startCount;
    sendByte(8'h00, 1); sendByte(8'h05, 0); sendByte(8'hFF, 2);
    repeat (20) @(negedge clk);
    chk(startCount == sc0 && gotCount == 0, "R3", "bad opcode ignored", startCount - sc0, 0);
    runCmd(8'h02, 32'h0000_0080, 64'd0, 1'b0);

    // R8 / R9: held ack, then busy until transmitter idle
    txMode = 1;
    gotCount = 0;
    sc0 = startCount;
    sendFrame(8'h01, 32'h0000_0010, 64'h1111_2222_3333_4444);
    checkLaunch(8'h01, 32'h0000_0010, 64'h1111_2222_3333_4444, sc0);
    serveOp(8'h01, 1'b0);
    repeat (10) @(negedge clk);
    chk(txValid == 1'b1 && txByte == 8'hAA && gotCount == 0, "R8", "ack held while not ready",
        {55'd0, txValid, txByte}, {55'd0, 1'b1, 8'hAA});
    txMode = 3;
    repeat (3) @(negedge clk);
    chk(gotCount == 1 && txValid == 1'b0, "R8", "ack taken on handshake", gotCount, 1);
    sc0 = startCount;
    sendFrame(8'h02, 32'h0000_0020, 64'd0);
    repeat (5) @(negedge clk);
    chk(startCount == sc0, "R9", "bytes dropped while tx busy", startCount - sc0, 0);
    txMode = 0;
    repeat (20) @(negedge clk);
    chk(startCount == sc0 && txValid == 1'b0, "R9", "no late start", startCount - sc0, 0);
    runCmd(8'h02, 32'h0000_0010, 64'd0, 1'b0);

    // R10: gap just under the limit lets the frame finish
    gotCount = 0;
    sc0 = startCount;
    sendByte(8'h02, 0); sendByte(8'h00, 0); sendByte(8'h00, 0);
    repeat (LIMIT - 96) @(negedge clk);
    sendByte(8'h12, 0); sendByte(8'h48, 0);
    checkLaunch(8'h02, 32'h0000_1248, 64'd0, sc0);
    serveOp(8'h02, 1'b0);
    collect(8'h02, 1'b0);

    // R10: gap past the limit drops the partial frame
    sc0 = startCount;
    sendByte(8'h04, 0); sendByte(8'h00, 0); sendByte(8'h00, 0);
    repeat (LIMIT + 100) @(negedge clk);
    chk(startCount == sc0, "R10", "partial frame dropped", startCount - sc0, 0);
    runCmd(8'h01, 32'h0000_2000, 64'hA5A5_5A5A_0F0F_F0F0, 1'b0);

    // constrained random mix
    for (int k = 0; k < 14; k++) begin
      int r;
      r = $urandom % 10;
      if (r < 3)      opc = 8'h01;
      else if (r < 6) opc = 8'h02;
      else if (r < 9) opc = 8'h03;
      else            opc = 8'h04;
      runCmd(opc, $urandom & 32'h03FF_F7F8, {$urandom, $urandom}, ($urandom % 3) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule